// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is one output cell of a sum-of-products programmable logic device. The array above it delivers a sum term, a dedicated output-enable term, and two signals shared by every cell: an asynchronous clear and a synchronous set. Two configuration bits choose what the cell does. One bit picks a registered path or a combinational path. The other bit sets the pin polarity to true or inverted. The cell drives a tri-state pin model made of a value and an enable. It returns one feedback signal to the array in both polarities.

In registered mode a D flip-flop holds the sum term, and the pin shows its state. Feedback comes from the flip-flop's complemented output, so the pin is an output only. In combinational mode the pin follows the sum term directly. Feedback then comes from the pin side of the buffer, so an external level on `pin_in` reaches the array whenever the driver is off. The clear and set act on the stored bit before the polarity stage. The level a pin shows after a clear therefore depends on the polarity setting.

A synchronous power-on reset puts the register into a known state. A test preload can force the register to either value, including states the normal logic never reaches.

Top module: `olmc_cell`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register becomes 0, whatever the preload, set and sum inputs are.
- R2: With `mode_sel`=0 (registered), each rising edge stores `sum_term` in the register. `pin_out` shows the stored bit when `pol_sel`=1 and its complement when `pol_sel`=0.
- R3: With `mode_sel`=1 (combinational), `pin_out` equals `sum_term` when `pol_sel`=1 and its complement when `pol_sel`=0, in the same cycle.
- R4: `pin_oe` equals `oe_term` in both modes.
- R5: While `async_clr` is high, the register is 0 at once, without a clock edge. This overrides the power-on reset, preload, set and sum inputs. With `pol_sel`=0, a cleared register drives `pin_out`=1.
- R6: When `sync_set` is high at a rising edge and preload is idle, the register becomes 1. `async_clr` wins over `sync_set`.
- R7: When `preload_en` is high at a rising edge, the register takes `preload_val`. Preload has priority over `sync_set` and `sum_term`. `async_clr` still overrides it.
- R8: With `mode_sel`=0, `fb_pos` is the complement of the register and `fb_neg` equals the register. Neither `pin_in` nor `oe_term` affects them.
- R9: With `mode_sel`=1, `fb_pos` is the pin level and `fb_neg` is its complement. The pin level is `pin_out` when `pin_oe`=1 and `pin_in` when `pin_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| mode_sel | input | 1 | 0 = registered, 1 = combinational |
| pol_sel | input | 1 | 0 = inverted pin, 1 = true pin |
| sum_term | input | 1 | Sum of products from the array |
| oe_term | input | 1 | Output-enable product term |
| async_clr | input | 1 | Shared asynchronous clear, active high |
| sync_set | input | 1 | Shared synchronous set, active high |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value forced by preload |
| pin_in | input | 1 | External level on the pin when it is not driven |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_pos | output | 1 | Feedback to the array, true polarity |
| fb_neg | output | 1 | Feedback to the array, complement |

## Verification
The hardest case to reach is `async_clr` acting between clock edges. It has to override a preload and a set that are both pending on the same edge, and its effect must show through both pin polarities. The stimulus first preloads a 1 into the register. It then raises the clear in the middle of a clock phase and checks the pin before any edge arrives. Next it holds the clear across an edge with preload and set both active. All other cases come from a full sweep of every input combination under all four mode and polarity settings. That sweep carries a running model of the stored bit.

// File: rtl/olmc_pkg.sv
// Package: shared encodings for the output macrocell.
// Assumes single-bit configuration fields decoded by every cell alike.
package olmc_pkg;
    typedef enum logic {
        MODE_REG  = 1'b0,
        MODE_COMB = 1'b1
    } olmc_mode_e;

    typedef enum logic {
        POL_INV  = 1'b0,
        POL_TRUE = 1'b1
    } olmc_pol_e;
endpackage

// File: rtl/olmc_state_reg.sv
// Module: olmc_state_reg
// The stored bit of the cell. Priority from highest: asynchronous clear,
// synchronous power-on reset, preload, synchronous set, sum term.
// Assumes async_clr is already qualified by the array and free of glitches.
module olmc_state_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic async_clr,
    input  logic sync_set,
    input  logic preload_en,
    input  logic preload_val,
    input  logic d_in,
    output logic q
);
    // Register update with the clear acting outside the clock.
    always_ff @(posedge clk or posedge async_clr) begin
        if (async_clr)
            q <= 1'b0;
        else if (!rst_n)
            q <= 1'b0;
        else if (preload_en)
            q <= preload_val;
        else if (sync_set)
            q <= 1'b1;
        else
            q <= d_in;
    end

    assert_por_clear_R1: assert property (@(posedge clk) disable iff (async_clr)
        $past(!rst_n) |-> (q == 1'b0));

    assert_clear_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (async_clr && $past(async_clr)) |-> (q == 1'b0));

    assert_preset_R6: assert property (@(posedge clk) disable iff (!rst_n || async_clr)
        (sync_set && !preload_en) |=> (q == 1'b1));

    assert_preload_R7: assert property (@(posedge clk) disable iff (!rst_n || async_clr)
        preload_en |=> (q == $past(preload_val)));

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n || async_clr)
        (!preload_en && !sync_set) |=> (q == $past(d_in)));
endmodule

// File: rtl/olmc_out_path.sv
// Module: olmc_out_path
// Selects the registered or combinational source and applies the polarity.
// Assumes the enable term passes straight to the pin driver.
module olmc_out_path
    import olmc_pkg::*;
(
    input  olmc_mode_e mode,
    input  olmc_pol_e  pol,
    input  logic       sum_term,
    input  logic       q,
    input  logic       oe_term,
    output logic       pin_out,
    output logic       pin_oe
);
    logic src;

    // Choose the data source and apply polarity.
    always_comb begin
        src     = (mode == MODE_COMB) ? sum_term : q;
        pin_out = (pol == POL_TRUE) ? src : ~src;
        pin_oe  = oe_term;
    end
endmodule

// File: rtl/olmc_feedback.sv
// Module: olmc_feedback
// Builds the feedback pair sent to the array. Registered mode uses the
// complemented register. Combinational mode uses the level on the pin.
// Assumes an undriven pin reads pin_in.
module olmc_feedback
    import olmc_pkg::*;
(
    input  olmc_mode_e mode,
    input  logic       q,
    input  logic       pin_out,
    input  logic       pin_oe,
    input  logic       pin_in,
    output logic       fb_pos,
    output logic       fb_neg
);
    logic pin_level;

    // Resolve the pin level and pick the feedback source.
    always_comb begin
        pin_level = pin_oe ? pin_out : pin_in;
        fb_pos    = (mode == MODE_COMB) ? pin_level : ~q;
        fb_neg    = ~fb_pos;
    end
endmodule

// File: rtl/olmc_cell.sv
// Module: olmc_cell (top)
// One configurable output cell. It contains the state register, the output
// path and the feedback select.
// Assumes configuration inputs stay static during normal operation.
module olmc_cell
    import olmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic pol_sel,
    input  logic sum_term,
    input  logic oe_term,
    input  logic async_clr,
    input  logic sync_set,
    input  logic preload_en,
    input  logic preload_val,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic fb_pos,
    output logic fb_neg
);
    olmc_mode_e mode;
    olmc_pol_e  pol;
    logic       q;

    // Decode the configuration bits into typed fields.
    always_comb begin
        mode = olmc_mode_e'(mode_sel);
        pol  = olmc_pol_e'(pol_sel);
    end

    olmc_state_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .async_clr   (async_clr),
        .sync_set    (sync_set),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .d_in        (sum_term),
        .q           (q)
    );

    olmc_out_path u_out (
        .mode     (mode),
        .pol      (pol),
        .sum_term (sum_term),
        .q        (q),
        .oe_term  (oe_term),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    olmc_feedback u_fb (
        .mode    (mode),
        .q       (q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_in  (pin_in),
        .fb_pos  (fb_pos),
        .fb_neg  (fb_neg)
    );

    assert_reg_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel) |-> (pin_out == (pol_sel ? q : !q)));

    assert_comb_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel |-> (pin_out == (pol_sel ? sum_term : !sum_term)));

    assert_reg_fb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel) |-> (fb_neg == q && fb_pos == !q));

    assert_undriven_fb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !oe_term) |-> (fb_pos == pin_in && fb_neg == !pin_in));
endmodule

// File: tb/tb_olmc_cell.sv
module tb_olmc_cell;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sel = 1'b0, pol_sel = 1'b1, sum_term = 1'b1, oe_term = 1'b0;
    logic async_clr = 1'b0, sync_set = 1'b1, preload_en = 1'b1, preload_val = 1'b1;
    logic pin_in = 1'b0;
    logic pin_out, pin_oe, fb_pos, fb_neg;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic q_exp = 1'b0;

    always #5 clk = ~clk;

    olmc_cell dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pol_sel(pol_sel),
        .sum_term(sum_term), .oe_term(oe_term), .async_clr(async_clr),
        .sync_set(sync_set), .preload_en(preload_en), .preload_val(preload_val),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .fb_pos(fb_pos), .fb_neg(fb_neg)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against a model built from the requirements.
    task automatic check_all();
        logic ep, src;
        if (mode_sel) ep = pol_sel ? sum_term : ~sum_term;
        else          ep = pol_sel ? q_exp : ~q_exp;
        src = mode_sel ? (oe_term ? ep : pin_in) : ~q_exp;
        check(mode_sel ? "R3 pin_out" : "R2 pin_out", pin_out, ep);
        check("R4 pin_oe", pin_oe, oe_term);
        check(mode_sel ? "R9 fb_pos" : "R8 fb_pos", fb_pos, src);
        check(mode_sel ? "R9 fb_neg" : "R8 fb_neg", fb_neg, ~src);
    endtask

    task automatic clear_ctl();
        sync_set = 1'b0; preload_en = 1'b0; preload_val = 1'b0;
        sum_term = 1'b0; oe_term = 1'b0; pin_in = 1'b0;
    endtask

    initial begin
        // R1: reset held with preload, set and sum all asking for 1.
        repeat (3) @(posedge clk);
        #1 check("R1 por clears register", pin_out, 1'b0);
        @(negedge clk);
        clear_ctl();
        rst_n = 1'b1;
        q_exp = 1'b0;

        // Full sweep: 4 configurations x 64 input vectors.
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int v = 0; v < 64; v++) begin
                @(negedge clk);
                mode_sel    = cfg[1];
                pol_sel     = cfg[0];
                sum_term    = v[0];
                oe_term     = v[1];
                pin_in      = v[2];
                sync_set    = v[3];
                preload_en  = v[4];
                preload_val = v[5];
                @(posedge clk);
                q_exp = preload_en ? preload_val : (sync_set ? 1'b1 : sum_term);
                #1 check_all();
            end
        end

        // R5/R6/R7: clear between edges, then held over an edge.
        for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            clear_ctl();
            mode_sel = 1'b0; pol_sel = p[0];
            preload_en = 1'b1; preload_val = 1'b1;
            @(posedge clk);
            #1 check("R7 preload sets 1", pin_out, p[0] ? 1'b1 : 1'b0);
            @(negedge clk);
            preload_en = 1'b0; sync_set = 1'b0; sum_term = 1'b1;
            #1 async_clr = 1'b1;
            #1 check("R5 clear without edge", pin_out, p[0] ? 1'b0 : 1'b1);
            check("R8 fb_neg after clear", fb_neg, 1'b0);
            preload_en = 1'b1; preload_val = 1'b1; sync_set = 1'b1;
            @(posedge clk);
            #1 check("R5 R6 R7 clear beats preload and set", pin_out, p[0] ? 1'b0 : 1'b1);
            @(negedge clk);
            clear_ctl();
            async_clr = 1'b0;
            q_exp = 1'b0;
            @(posedge clk);
            #1 check_all();
        end

        // R6: set with preload idle after a clear.
        @(negedge clk);
        mode_sel = 1'b0; pol_sel = 1'b1; sync_set = 1'b1;
        @(posedge clk);
        #1 check("R6 set gives 1", pin_out, 1'b1);
        @(negedge clk);
        clear_ctl();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule